// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a processor's local interrupt controller. A free-running prescaler divides the base clock by a power of two picked by a 3-bit divide code. Each prescaled tick moves a down-counter that software starts by writing an initial count. When the count runs out, the timer raises a one-cycle interrupt request carrying the 8-bit vector from its vector entry. The request is always marked edge-triggered. A mask bit in the entry suppresses the request, but the counter keeps running while masked. A periodic select bit makes the counter reload and fire again every initial+1 ticks. Without it, the timer fires once and stops.

Software reaches the timer through a simple register port. Writes go through `wr_en`/`wr_sel`/`wr_data`. Reads are combinational through `rd_sel`/`rd_data`. There are four registers, on selects 0 to 3: the vector entry, the initial count, the live current count and the divide configuration. The counter's controller has two states. `ST_IDLE` means stopped. `ST_RUN` means counting. The named transitions are:
- LOAD: a non-zero initial-count write, which enters `ST_RUN`.
- STOP: a zero initial-count write, which enters `ST_IDLE`.
- EXPIRE_ONESHOT: a tick at count zero without the periodic bit, which goes from `ST_RUN` to `ST_IDLE`.
- EXPIRE_RELOAD: a tick at count zero with the periodic bit, which stays in `ST_RUN` and reloads.
- INIT: `init_i` or reset, which enters `ST_IDLE` from any state.

Top module: `lct_timer`

## Requirements
- R1: After reset or a cycle with `init_i` high, the registers hold their reset values and no request is raised. The divide register (select 3) reads 0. The initial count (select 1) reads 0. The current count (select 2) reads 0. The vector entry (select 0) reads 0x00010000.
- R2: A write to the divide register (select 3) keeps only data bits 3, 1 and 0. It reads back as `wr_data & 0xB`.
- R3: The divide code is {divide bit 3, divide bits 1:0}. The counter advances once every 2^((code+1) mod 8) base clocks. Code 7 advances every clock and code 0 every second clock. The prescaler restarts from zero on each initial-count write.
- R4: In the vector entry (select 0), bit 17 selects periodic mode, bit 16 masks the request and bits 7:0 give the vector. All other bits are dropped and read as 0.
- R5: A write of a non-zero N to the initial count (select 1) loads the counter with N on that edge. The current count then reads N.
- R6: In one-shot mode, the count falls by one per tick down to 0. The next tick raises one request and the count stays at 0 with no further request.
- R7: In periodic mode, a tick at count 0 raises a request and reloads the initial count, so requests repeat every initial+1 ticks.
- R8: While the mask bit is set, no request is raised, but the count keeps falling and reloading.
- R9: Writing 0 to the initial count stops the timer. No request follows in either mode and the current count reads 0.
- R10: Writes to the current count (select 2) are ignored. Reads of select 2 return the live counter.
- R11: A request is a single-cycle `irq_valid` pulse in the cycle after the expiring tick's edge. It carries the entry's vector on `irq_vector`, and `irq_level` stays 0 (edge-triggered).
- R12: An initial-count write on the same edge as an expiring tick wins. The counter reloads with the written value and no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous INIT: returns all timer state to reset values |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 entry, 1 initial, 2 current, 3 divide) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select, same encoding |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_level | output | 1 | Trigger mode of the request, 0 = edge |

## Verification
The sharpest collision is an initial-count write landing on the very edge where a zero count meets a prescaled tick. On that edge, the reload path and the expiry path both want the counter. The bench runs a periodic timer at divide-by-1 and watches its own reference model until the count sits at zero. It then issues the write so that it lands on the expiring edge. It judges the result by the absence of `irq_valid` in the next cycle and by the newly written value on the current-count readback. A second overlap is a write to the entry or divide register on a tick edge, where the old settings must govern that tick. The per-clock comparison against the model covers this.

// File: rtl/lct_pkg.sv
package lct_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lct_state_e;

    localparam logic [1:0] SEL_ENTRY = 2'd0;
    localparam logic [1:0] SEL_INIT  = 2'd1;
    localparam logic [1:0] SEL_CUR   = 2'd2;
    localparam logic [1:0] SEL_DIV   = 2'd3;

    localparam int ENTRY_PERIODIC_BIT = 17;
    localparam int ENTRY_MASK_BIT     = 16;
    localparam logic [3:0] DIV_KEEP   = 4'hB;

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [SHIFT_W-1:0] div_code,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0]   pre_q;
    logic [SHIFT_W-1:0] shift;
    logic [PRE_W:0]     span;

    // shift wraps modulo 2**SHIFT_W, so the top code divides by one
    assign shift = div_code + SHIFT_W'(1);
    assign span  = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
    assign tick  = (pre_q & span[PRE_W-1:0]) == span[PRE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pre_q <= '0;
        else if (clear) pre_q <= '0;
        else            pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [3:0]        div_raw,
    output logic [2:0]        div_code,
    output logic              periodic,
    output logic              masked,
    output logic [VEC_W-1:0]  vector,
    output logic [DATA_W-1:0] init_val,
    output logic              load
);
    assign load     = wr_en && (wr_sel == SEL_INIT) && !init_i;
    assign div_code = {div_raw[3], div_raw[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_raw  <= '0;
            periodic <= 1'b0;
            masked   <= 1'b1;
            vector   <= '0;
            init_val <= '0;
        end else if (init_i) begin
            div_raw  <= '0;
            periodic <= 1'b0;
            masked   <= 1'b1;
            vector   <= '0;
            init_val <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_ENTRY: begin
                    periodic <= wr_data[ENTRY_PERIODIC_BIT];
                    masked   <= wr_data[ENTRY_MASK_BIT];
                    vector   <= wr_data[VEC_W-1:0];
                end
                SEL_INIT: init_val <= wr_data;
                SEL_DIV:  div_raw  <= wr_data[3:0] & DIV_KEEP;
                SEL_CUR:  ;
            endcase
        end
    end
endmodule

// File: rtl/lct_counter.sv
module lct_counter
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] count,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    lct_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             fire;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire    = 1'b0;
        if (init_i) begin
            state_d = ST_IDLE;
            count_d = '0;
        end else if (load) begin
            count_d = load_val;
            state_d = (load_val != '0) ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (tick) begin
                        if (count_q != '0) begin
                            count_d = count_q - CNT_W'(1);
                        end else begin
                            fire = !masked;
                            if (periodic) count_d = init_val;
                            else          state_d = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= fire;
            if (fire) irq_vector <= vector;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VEC_W   = 8,
    parameter int SHIFT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              irq_level
);
    logic [3:0]        div_raw;
    logic [2:0]        div_code;
    logic              periodic, masked, load, tick;
    logic [VEC_W-1:0]  vector;
    logic [DATA_W-1:0] init_val, cur_count, entry_word;

    lct_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .div_raw(div_raw), .div_code(div_code), .periodic(periodic),
        .masked(masked), .vector(vector), .init_val(init_val), .load(load)
    );

    lct_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(load | init_i),
        .div_code(div_code[SHIFT_W-1:0]), .tick(tick)
    );

    lct_counter #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .tick(tick),
        .load(load), .load_val(wr_data), .init_val(init_val),
        .periodic(periodic), .masked(masked), .vector(vector),
        .count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always_comb begin
        entry_word                     = '0;
        entry_word[ENTRY_PERIODIC_BIT] = periodic;
        entry_word[ENTRY_MASK_BIT]     = masked;
        entry_word[VEC_W-1:0]          = vector;
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ENTRY: rd_data = entry_word;
            SEL_INIT:  rd_data = init_val;
            SEL_CUR:   rd_data = cur_count;
            SEL_DIV:   rd_data = {{(DATA_W-4){1'b0}}, div_raw};
        endcase
    end

    assign irq_level = 1'b0;
endmodule

// File: rtl/lct_timer_checker.sv
module lct_timer_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic        init_i,
    input logic [1:0]  rd_sel,
    input logic [31:0] rd_data,
    input logic        irq_valid,
    input logic [31:0] cur_count,
    input logic        periodic,
    input logic        masked
);
    logic load_w;
    assign load_w = wr_en && (wr_sel == 2'd1) && !init_i;

    AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid); // R11

    AST_DIV_READ_KEPT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> (rd_data[31:4] == '0 && !rd_data[2])); // R2

    AST_ENTRY_READ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd0) |-> (rd_data[31:18] == '0 && rd_data[15:8] == '0)); // R4

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (cur_count == $past(wr_data))); // R5

    AST_ONESHOT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !periodic && !load_w) |=> (cur_count == '0)); // R6

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(cur_count) == '0)); // R7

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(masked)); // R8
endmodule

bind lct_timer lct_timer_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .init_i(init_i), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_valid(irq_valid), .cur_count(cur_count), .periodic(periodic),
    .masked(masked)
);

// File: tb/lct_timer_bench.sv
module lct_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic        irq_level;

    always #4 clk = ~clk;   // 125 MHz

    lct_timer u_lct_timer (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .irq_level(irq_level)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [31:0] m_div = '0, m_init = '0, m_entry = 32'h0001_0000, m_cnt = '0;
    bit          m_run = 1'b0, m_irq = 1'b0;
    int          m_pre = 0;
    logic [7:0]  m_vec = '0;

    always @(posedge clk) begin : ref_model
        int sh;
        bit tk;
        if (!rst_n || init_i) begin
            m_div = '0; m_init = '0; m_entry = 32'h0001_0000; m_cnt = '0;
            m_run = 1'b0; m_irq = 1'b0; m_pre = 0;
        end else begin
            sh = (((int'(m_div[3]) * 4) + int'(m_div[1:0])) + 1) % 8;
            tk = (m_pre % (1 << sh)) == ((1 << sh) - 1);
            m_irq = 1'b0;
            if (wr_en && wr_sel == 2'd1) begin
                m_init = wr_data; m_cnt = wr_data;
                m_run = (wr_data != 0); m_pre = 0;
            end else begin
                m_pre = (m_pre + 1) % 128;
                if (m_run && tk) begin
                    if (m_cnt != 0) m_cnt = m_cnt - 1;
                    else begin
                        if (!m_entry[16]) begin m_irq = 1'b1; m_vec = m_entry[7:0]; end
                        if (m_entry[17]) m_cnt = m_init;
                        else m_run = 1'b0;
                    end
                end
            end
            if (wr_en && wr_sel == 2'd3) m_div = wr_data & 32'hB;
            if (wr_en && wr_sel == 2'd0) m_entry = wr_data & 32'h0003_00FF;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] s);
        case (s)
            2'd0:    return m_entry;
            2'd1:    return m_init;
            2'd2:    return m_cnt;
            default: return m_div;
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        vectors++;
        if (rd_data !== exp_rd(rd_sel)) begin
            miscompares++;
            $display("FAIL %s sel=%0d rd_data actual=%h expected=%h", cur_req, rd_sel, rd_data, exp_rd(rd_sel));
        end
        vectors++;
        if (irq_valid !== m_irq || irq_level !== 1'b0 || (m_irq && irq_vector !== m_vec)) begin
            miscompares++;
            $display("FAIL R11/%s irq actual=%b/%h/%b expected=%b/%h/0", cur_req,
                     irq_valid, irq_vector, irq_level, m_irq, m_vec);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic read_all();
        for (int s = 0; s < 4; s++) begin rd_sel = 2'(s); step(); end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        read_all();

        // R2: divide keeps bits 3,1,0
        cur_req = "R2";
        rd_sel = 2'd3;
        wr(2'd3, 32'hFFFF_FFFF); step();
        wr(2'd3, 32'h0000_0004); step();

        // R4: entry fields
        cur_req = "R4";
        rd_sel = 2'd0;
        wr(2'd0, 32'hFFFF_FFFF); step();
        wr(2'd0, 32'h0000_0040); step();

        // R5, R6, R3: one-shot, divide by 1 (code 7)
        cur_req = "R5";
        wr(2'd3, 32'hB);
        rd_sel = 2'd2;
        wr(2'd1, 32'd5);
        cur_req = "R6";
        idle(12);

        // R3: one-shot, divide by 2 (code 0)
        cur_req = "R3";
        wr(2'd3, 32'h0);
        wr(2'd1, 32'd3);
        idle(14);
        // R3: divide by 16 (code 3)
        wr(2'd3, 32'h3);
        wr(2'd1, 32'd2);
        idle(60);

        // R7: periodic, divide by 4 (code 1)
        cur_req = "R7";
        wr(2'd0, 32'h0002_0077);
        wr(2'd3, 32'h1);
        wr(2'd1, 32'd2);
        idle(40);

        // R10: write to current count ignored while running
        cur_req = "R10";
        wr(2'd2, 32'h0000_1234);
        idle(6);

        // R8: masked periodic keeps counting
        cur_req = "R8";
        wr(2'd0, 32'h0003_0077);
        idle(30);

        // R9: zero initial count stops the timer (periodic, then one-shot)
        cur_req = "R9";
        wr(2'd0, 32'h0002_0011);
        wr(2'd1, 32'd0);
        idle(20);
        wr(2'd0, 32'h0000_0011);
        wr(2'd1, 32'd0);
        idle(20);

        // R12: initial-count write on the expiring tick
        cur_req = "R12";
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0002_0033);
        wr(2'd1, 32'd3);
        for (int k = 0; k < 3; k++) begin
            while (!(m_run && m_cnt == 0)) step();
            wr(2'd1, 32'd6);
            vectors++;
            if (irq_valid !== 1'b0 || rd_data !== 32'd6) begin
                miscompares++;
                $display("FAIL R12 irq/count actual=%b/%0d expected=0/6", irq_valid, rd_data);
            end
            idle(2);
        end
        idle(10);

        // R1: INIT during a running periodic timer
        cur_req = "R1";
        wr(2'd3, 32'h2);
        init_i = 1'b1;
        step();
        init_i = 1'b0;
        read_all();
        idle(10);

        finish_run();
    end
endmodule